// File: doc/BRIEF.md
# Single-Wire Byte Sequencer with Strong Pull-Up Hold

This block turns one byte-level request into eight bit slots on a single-wire bus. The caller chooses one of three operations: send a byte, receive a byte, or exchange a byte. The block then passes the bits, least-significant first, to a separate slot generator over a start/done handshake. It assembles the sampled levels into a received byte and pulses `done` when the byte is complete. The slot generator owns all bus timing. This block only orders the slots.

The caller can also leave a one-shot strong pull-up request, given as a duration in milliseconds. The request is consumed by the next send or exchange. The pull-up is armed when the eighth slot is issued. After the last slot completes, the block holds the strong pull-up enable for the requested time, then releases it and clears the request. If the pull-up is disabled, the block still waits out the same time, but it never drives the enable. A receive leaves the request pending for a later send.

Top module: `owb_byte_xfer`

## Requirements
- R1: A transfer request (`xfer_valid`) is accepted only while `busy` is low. `busy` rises on the next cycle and stays high until `done`. Transfer and pull-up requests presented while `busy` is high have no effect.
- R2: An accepted transfer issues exactly eight slots, least-significant bit first. Each `slot_start` is a one-cycle pulse. The next pulse follows one cycle after the slot generator's `slot_done`.
- R3: Op code 2'b00 (send) drives `slot_bit` with bit i of `xfer_byte` in slot i.
- R4: Op code 2'b01 (receive) drives `slot_bit` = 1 in every slot and places the level sampled in slot i (`slot_sample` with `slot_done`) at bit i of `rx_byte`.
- R5: Op codes 2'b10 and 2'b11 (exchange) drive bit i of `xfer_byte` in slot i and collect the sample of slot i at bit i of `rx_byte`.
- R6: `done` is a one-cycle pulse. With no hold, it comes one cycle after the eighth `slot_done`. `rx_byte` is valid at `done` and does not change while `busy` is low.
- R7: `spu_set` while idle loads `spu_ms` as the pending pull-up duration. A value of zero cancels an earlier request.
- R8: Consider a send or exchange with a nonzero pending duration D, where `spu_enable` is high when the eighth slot is issued. `spu_drive` is then high for exactly D × CYCLES_PER_MS cycles, starting one cycle after the eighth `slot_done`. `done` follows in the next cycle.
- R9: With `spu_enable` low in the same case, `done` is still delayed by D × CYCLES_PER_MS cycles, and `spu_drive` stays low.
- R10: The pending duration is cleared once the hold ends, so the next transfer has no hold. A receive neither uses nor clears it.
- R11: `spu_drive` is never high while a slot is outstanding, from `slot_start` up to and including the cycle of `slot_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | Transfer request |
| xfer_op | input | 2 | Operation: 00 send, 01 receive, 10/11 exchange |
| xfer_byte | input | DATA_W | Byte to send or exchange |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | DATA_W | Sampled byte |
| slot_start | output | 1 | Slot command pulse to slot generator |
| slot_bit | output | 1 | Bit value for the commanded slot |
| slot_done | input | 1 | Slot generator finished the slot |
| slot_sample | input | 1 | Bus level sampled in the slot, valid with slot_done |
| spu_set | input | 1 | Load a pull-up request |
| spu_ms | input | MS_W | Pull-up duration in milliseconds, 0 cancels |
| spu_enable | input | 1 | Strong pull-up permitted |
| spu_drive | output | 1 | Strong pull-up enable |

## Verification
A wrong bit index or wrong op decode shows at `slot_bit` within the same slot, and a wrong sample placement shows in `rx_byte` at `done`. A stale or lost pending duration shows only on a later transfer, as a wrong gap between the eighth `slot_done` and `done`. That gap is measured in cycles and is visible whether or not `spu_drive` is permitted. A mis-armed pull-up would overlap an outstanding slot or stretch the hold by a millisecond tick. The bench therefore counts `spu_drive` cycles exactly on every transfer.

// File: rtl/owb_xfer_pkg.sv
package owb_xfer_pkg;
    typedef enum logic [1:0] {
        OP_SEND   = 2'b00,
        OP_RECV   = 2'b01,
        OP_XCHG   = 2'b10,
        OP_XCHG_B = 2'b11
    } xfer_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_HOLD,
        ST_DONE
    } seq_st_e;
endpackage

// File: rtl/owb_hold_timer.sv
module owb_hold_timer #(
    parameter int CYCLES_PER_MS = 125000,
    parameter int MS_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] ms_in,
    input  logic            run,
    output logic            expire
);
    localparam int TICK_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
    localparam logic [TICK_W-1:0] TICK_TOP = TICK_W'(CYCLES_PER_MS - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [MS_W-1:0]   left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.tick = TICK_TOP;
            tmr_d.left = ms_in;
        end else if (run) begin
            if (tmr_q.tick == '0) begin
                tmr_d.tick = TICK_TOP;
                tmr_d.left = tmr_q.left - 1'b1;
            end else begin
                tmr_d.tick = tmr_q.tick - 1'b1;
            end
        end
    end

    assign expire = run && (tmr_q.tick == '0) && (tmr_q.left == MS_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/owb_rx_collect.sv
module owb_rx_collect #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [IDX_W-1:0]  idx,
    input  logic              sample,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0] rx_d, rx_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            rx_d[i] = rx_q[i];
            if (capture && (idx == IDX_W'(i))) rx_d[i] = sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx = rx_q;
endmodule

// File: rtl/owb_byte_xfer.sv
module owb_byte_xfer
    import owb_xfer_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int MS_W          = 8,
    parameter int CYCLES_PER_MS = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [1:0]        xfer_op,
    input  logic [DATA_W-1:0] xfer_byte,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              slot_start,
    output logic              slot_bit,
    input  logic              slot_done,
    input  logic              slot_sample,
    input  logic              spu_set,
    input  logic [MS_W-1:0]   spu_ms,
    input  logic              spu_enable,
    output logic              spu_drive
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  idx;
        xfer_op_e          op;
        logic [DATA_W-1:0] tx;
        logic [MS_W-1:0]   pend;
        logic              hold;
        logic              armed;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_bit;
    logic capture;
    logic tmr_load;
    logic tmr_expire;

    assign last_bit = (seq_q.idx == LAST_IDX);
    assign capture  = (seq_q.st == ST_WAIT) && slot_done;
    assign tmr_load = capture && last_bit && seq_q.hold;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (spu_set) seq_d.pend = spu_ms;
                if (xfer_valid) begin
                    seq_d.st    = ST_ISSUE;
                    seq_d.idx   = '0;
                    seq_d.op    = xfer_op_e'(xfer_op);
                    seq_d.tx    = xfer_byte;
                    seq_d.hold  = 1'b0;
                    seq_d.armed = 1'b0;
                end
            end
            ST_ISSUE: begin
                seq_d.st = ST_WAIT;
                if (last_bit) begin
                    seq_d.hold  = (seq_q.pend != '0) && (seq_q.op != OP_RECV);
                    seq_d.armed = (seq_q.pend != '0) && (seq_q.op != OP_RECV) && spu_enable;
                end
            end
            ST_WAIT: begin
                if (slot_done) begin
                    if (last_bit) begin
                        seq_d.st = seq_q.hold ? ST_HOLD : ST_DONE;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                        seq_d.st  = ST_ISSUE;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expire) begin
                    seq_d.st    = ST_DONE;
                    seq_d.pend  = '0;
                    seq_d.hold  = 1'b0;
                    seq_d.armed = 1'b0;
                end
            end
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.st  <= ST_IDLE;
            seq_q.op  <= OP_SEND;
        end else begin
            seq_q <= seq_d;
        end
    end

    owb_hold_timer #(
        .CYCLES_PER_MS(CYCLES_PER_MS),
        .MS_W         (MS_W)
    ) hold_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .ms_in (seq_q.pend),
        .run   (seq_q.st == ST_HOLD),
        .expire(tmr_expire)
    );

    owb_rx_collect #(
        .DATA_W(DATA_W)
    ) rx_col_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .idx    (seq_q.idx),
        .sample (slot_sample),
        .rx     (rx_byte)
    );

    assign busy       = (seq_q.st != ST_IDLE);
    assign done       = (seq_q.st == ST_DONE);
    assign slot_start = (seq_q.st == ST_ISSUE);
    assign slot_bit   = (seq_q.op == OP_RECV) ? 1'b1 : seq_q.tx[seq_q.idx];
    assign spu_drive  = (seq_q.st == ST_HOLD) && seq_q.armed;
endmodule

// File: rtl/owb_byte_xfer_chk.sv
module owb_byte_xfer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              slot_start,
    input logic              slot_done,
    input logic              spu_drive
);
    logic in_slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          in_slot_q <= 1'b0;
        else if (slot_start) in_slot_q <= 1'b1;
        else if (slot_done)  in_slot_q <= 1'b0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R6
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy) else $error("busy after done"); // R1
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start) else $error("slot_start not a pulse"); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> busy) else $error("slot issued while idle"); // R2
    AST_RX_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rx_byte)) else $error("rx_byte moved while idle"); // R6
    AST_SPU_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        spu_drive |-> busy) else $error("pull-up outside transfer"); // R8
    AST_SPU_NOT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> !spu_drive) else $error("pull-up at slot start"); // R11
    AST_SPU_NOT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot_q |-> !spu_drive) else $error("pull-up during slot"); // R11
endmodule

bind owb_byte_xfer owb_byte_xfer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .slot_start(slot_start),
    .slot_done (slot_done),
    .spu_drive (spu_drive)
);

// File: tb/owb_byte_xfer_tb_top.sv
module owb_byte_xfer_tb_top;
    localparam int CPM = 4;
    localparam int NVEC = 7;
    // {op[42:41], byte[40:33], resp[32:25], ms[24:17], en[16], exp_rx[15:8], exp_tx[7:0]}
    localparam logic [42:0] VEC [NVEC] = '{
        {2'b00, 8'hA5, 8'h00, 8'd0, 1'b1, 8'h00, 8'hA5},
        {2'b01, 8'h00, 8'h3C, 8'd0, 1'b1, 8'h3C, 8'hFF},
        {2'b10, 8'h96, 8'h5A, 8'd0, 1'b0, 8'h5A, 8'h96},
        {2'b00, 8'h01, 8'hFF, 8'd2, 1'b1, 8'hFF, 8'h01},
        {2'b10, 8'h80, 8'h81, 8'd3, 1'b0, 8'h81, 8'h80},
        {2'b11, 8'h7E, 8'hC3, 8'd1, 1'b1, 8'hC3, 8'h7E},
        {2'b00, 8'hFF, 8'h00, 8'd0, 1'b0, 8'h00, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_valid = 1'b0;
    logic [1:0] xfer_op = 2'b00;
    logic [7:0] xfer_byte = 8'h00;
    logic busy, done, slot_start, slot_bit, spu_drive;
    logic [7:0] rx_byte;
    logic slot_done = 1'b0;
    logic slot_sample = 1'b0;
    logic spu_set = 1'b0;
    logic [7:0] spu_ms = 8'd0;
    logic spu_enable = 1'b1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] resp_byte = 8'h00;
    logic [7:0] tx_log = 8'h00;
    int slot_cnt = 0;
    int last_cyc = 0;
    int done_cyc = 0;
    int done_cnt = 0;
    int spu_cnt = 0;
    int ovl = 0;
    logic outstanding = 1'b0;
    logic done_seen = 1'b0;

    owb_byte_xfer #(.DATA_W(8), .MS_W(8), .CYCLES_PER_MS(CPM)) dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_op(xfer_op),
        .xfer_byte(xfer_byte), .busy(busy), .done(done), .rx_byte(rx_byte),
        .slot_start(slot_start), .slot_bit(slot_bit), .slot_done(slot_done),
        .slot_sample(slot_sample), .spu_set(spu_set), .spu_ms(spu_ms),
        .spu_enable(spu_enable), .spu_drive(spu_drive)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // slot generator model
    initial begin
        forever begin
            @(negedge clk);
            while (slot_start) begin
                int k;
                k = slot_cnt;
                outstanding = 1'b1;
                tx_log[k[2:0]] = slot_bit;
                slot_cnt = slot_cnt + 1;
                repeat (2) @(negedge clk);
                slot_sample = resp_byte[k[2:0]];
                slot_done = 1'b1;
                last_cyc = cyc;
                @(negedge clk);
                slot_done = 1'b0;
                outstanding = 1'b0;
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (done) begin
            done_cnt = done_cnt + 1;
            done_seen = 1'b1;
            done_cyc = cyc;
        end
        if (spu_drive) spu_cnt = spu_cnt + 1;
        if (spu_drive && outstanding) ovl = ovl + 1;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic pull_req(input logic [7:0] ms);
        @(negedge clk);
        spu_set = 1'b1;
        spu_ms = ms;
        @(negedge clk);
        spu_set = 1'b0;
    endtask

    task automatic xfer(input logic [1:0] op, input logic [7:0] b, input logic [7:0] resp);
        @(negedge clk);
        resp_byte = resp;
        slot_cnt = 0;
        tx_log = 8'h00;
        done_cnt = 0;
        spu_cnt = 0;
        ovl = 0;
        done_seen = 1'b0;
        xfer_valid = 1'b1;
        xfer_op = op;
        xfer_byte = b;
        @(negedge clk);
        xfer_valid = 1'b0;
        while (!done_seen) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R6)
        chk(!busy && !done && !slot_start && !spu_drive, "R1 reset outputs",
            {busy, done, slot_start, spu_drive}, 0);
        chk(rx_byte == 8'h00, "R6 reset rx", rx_byte, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [42:0] e;
            int hcyc;
            e = VEC[v];
            spu_enable = e[16];
            if (e[24:17] != 8'd0) pull_req(e[24:17]);
            xfer(e[42:41], e[40:33], e[32:25]);
            hcyc = int'(e[24:17]) * CPM;
            chk(slot_cnt == 8, "R2 eight slots", slot_cnt, 8);
            chk(tx_log == e[7:0], "R3/R4/R5 slot bits", tx_log, e[7:0]);
            if (e[42:41] != 2'b00)
                chk(rx_byte == e[15:8], "R4/R5 rx byte", rx_byte, e[15:8]);
            chk(done_cnt == 1, "R6 done pulse", done_cnt, 1);
            chk(done_cyc - last_cyc == 1 + hcyc, "R8/R9 done gap",
                done_cyc - last_cyc, 1 + hcyc);
            chk(spu_cnt == (e[16] ? hcyc : 0), "R8/R9 pull-up cycles",
                spu_cnt, e[16] ? hcyc : 0);
            chk(ovl == 0, "R11 no overlap", ovl, 0);
        end

        // R10: pending cleared after the hold
        spu_enable = 1'b1;
        pull_req(8'd2);
        xfer(2'b00, 8'h33, 8'h00);
        chk(spu_cnt == 2 * CPM, "R8 hold before clear", spu_cnt, 2 * CPM);
        xfer(2'b00, 8'h33, 8'h00);
        chk(done_cyc - last_cyc == 1, "R10 cleared after hold", done_cyc - last_cyc, 1);
        chk(spu_cnt == 0, "R10 no second pull-up", spu_cnt, 0);

        // R7: zero cancels
        pull_req(8'd3);
        pull_req(8'd0);
        xfer(2'b10, 8'h0F, 8'hF0);
        chk(done_cyc - last_cyc == 1, "R7 zero cancels", done_cyc - last_cyc, 1);
        chk(spu_cnt == 0, "R7 cancel no drive", spu_cnt, 0);

        // R10: receive keeps pending
        pull_req(8'd2);
        xfer(2'b01, 8'h00, 8'hA1);
        chk(done_cyc - last_cyc == 1, "R10 receive no hold", done_cyc - last_cyc, 1);
        chk(spu_cnt == 0, "R10 receive no drive", spu_cnt, 0);
        xfer(2'b00, 8'h44, 8'h00);
        chk(spu_cnt == 2 * CPM, "R10 pending kept past receive", spu_cnt, 2 * CPM);

        // R1/R7: requests while busy are ignored
        @(negedge clk);
        resp_byte = 8'h5C;
        slot_cnt = 0;
        done_seen = 1'b0;
        spu_cnt = 0;
        xfer_valid = 1'b1;
        xfer_op = 2'b00;
        xfer_byte = 8'hC8;
        @(negedge clk);
        xfer_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R1 busy during transfer", busy, 1);
        xfer_valid = 1'b1;
        xfer_op = 2'b01;
        spu_set = 1'b1;
        spu_ms = 8'd3;
        @(negedge clk);
        xfer_valid = 1'b0;
        spu_set = 1'b0;
        while (!done_seen) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(slot_cnt == 8, "R1 busy request ignored", slot_cnt, 8);
        chk(!busy, "R1 idle after done", busy, 0);
        chk(tx_log == 8'hC8, "R3 bits kept", tx_log, 8'hC8);
        xfer(2'b00, 8'h12, 8'h00);
        chk(done_cyc - last_cyc == 1, "R7 busy pull-up request ignored",
            done_cyc - last_cyc, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule